// File: doc/BRIEF.md
# Exposure Frame Controller

This block sequences the exposure of an image sensor frame by frame. A frame passes through three phases: vertical readout, where rows are clocked out line by line; timed integration, where a millisecond tick is counted; and photodiode transfer, where the collected charge is moved into the vertical registers. The block asks the external timing generator to start that transfer with a one-cycle vertical-drive request. It also gives an exposure indication for external monitoring.

The exposure length has two parts, and both are chosen by a 5-bit select code. The first part is an electronic shutter line inside the readout: the block pulses a shutter output when the readout reaches that line, which discards the charge gathered so far and so shortens the exposure. The second part is an extra number of millisecond ticks counted after readout ends. The transfer request is raised only once the readout (and with it any shutter line) is finished and the tick count has been reached. Code 0 is the default: no shutter pulse and no extra ticks. The select code is captured once per frame, when a new readout begins, so the whole frame uses one consistent setting.

The surrounding timing logic reports each transferred line with `line_adv` and the end of readout with `readout_done`. Generating pixel and line clocks is done elsewhere.

Top module: `exposure_frame_ctrl`

## Requirements
- R1: After reset all outputs are low, the block is in readout, and the captured select code is 0 whatever `int_sel` holds.
- R2: The select code is captured only at the start of a new frame (the `line_adv` that leaves photodiode transfer); changes of `int_sel` during a frame have no effect on that frame.
- R3: For a code c with 1 <= c <= SHUT_CODES, the shutter line is LINES - c*(LINES/(SHUT_CODES+1)), counting the lines of the readout from 0; `shut_pulse` is high for exactly the one cycle after the clock edge that accepts that line's `line_adv`.
- R4: For code 0 and for every code above SHUT_CODES the shutter line is NO_SHUT_LINE, which lies beyond the last line, so no shutter pulse occurs in the frame.
- R5: The tick target is 0 for codes up to SHUT_CODES and (c - SHUT_CODES)*MS_STEP above that; the tick counter clears when integration begins and `vd_req` rises on the clock edge after the edge that brings the count to the target (with target 0, the second edge after `readout_done` is accepted).
- R6: `vd_req` is a single-cycle pulse; `integrate` is low while `vd_req` is high and stays low until the next shutter pulse or integration phase.
- R7: `integrate` is high throughout the timed integration phase and also during readout from the shutter pulse onward.
- R8: In photodiode transfer `ms_tick` and `readout_done` are ignored; the first `line_adv` starts a new readout and is not counted as a readout line.
- R9: When the shutter line's `line_adv` and `readout_done` arrive in the same cycle, both take effect: the shutter pulse fires and integration begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| int_sel | input | SEL_W | Exposure select code |
| line_adv | input | 1 | One-cycle pulse per transferred line |
| readout_done | input | 1 | End of vertical readout |
| shut_pulse | output | 1 | Electronic shutter pulse |
| vd_req | output | 1 | Vertical-drive request, starts photodiode transfer |
| integrate | output | 1 | Exposure in progress indication |

## Verification
The two functions that can land in one cycle are the shutter trigger and the end of readout: the bench drives the shutter line's `line_adv` together with `readout_done` and expects, at the next sample, both a shutter pulse and an active integration phase, followed by the transfer request two edges later. A second collision is a tick arriving once the count already equals the target; the bench keeps delivering ticks at a fixed pitch and judges that the request comes exactly two edges after the final counted tick and only once. Every select code is swept, with the shutter line and tick target recomputed arithmetically in the bench.

// File: rtl/exp_pkg.sv
package exp_pkg;
   typedef enum logic [1:0] {
      ST_READOUT = 2'd0,
      ST_INTEG   = 2'd1,
      ST_PDXFER  = 2'd2
   } exp_state_t;
endpackage

// File: rtl/exp_sel_decode.sv
module exp_sel_decode #(
   parameter int SEL_W        = 5,
   parameter int LINES        = 1104,
   parameter int NO_SHUT_LINE = 2040,
   parameter int SHUT_CODES   = 7,
   parameter int MS_STEP      = 4,
   parameter int LW           = 11,
   parameter int TW           = 7
) (
   input  logic [SEL_W-1:0] sel,
   output logic [LW-1:0]    shut_line,
   output logic [TW-1:0]    tick_target
);
   localparam int STEP = LINES / (SHUT_CODES + 1);

   int code;
   always_comb begin
      code = int'(sel);
      if (code >= 1 && code <= SHUT_CODES) begin
         shut_line   = LW'(LINES - code * STEP);
         tick_target = '0;
      end else begin
         shut_line   = LW'(NO_SHUT_LINE);
         tick_target = (code > SHUT_CODES) ? TW'((code - SHUT_CODES) * MS_STEP) : '0;
      end
   end
endmodule

// File: rtl/exp_line_track.sv
module exp_line_track #(
   parameter int LW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          enable,
   input  logic          line_adv,
   input  logic [LW-1:0] shut_line,
   output logic          shut_pulse,
   output logic          shut_seen
);
   logic [LW-1:0] line_cnt;
   logic          hit;

   assign hit = enable && line_adv && (line_cnt == shut_line);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_cnt   <= '0;
         shut_pulse <= 1'b0;
         shut_seen  <= 1'b0;
      end else begin
         shut_pulse <= hit;
         if (clear) begin
            line_cnt  <= '0;
            shut_seen <= 1'b0;
         end else begin
            if (enable && line_adv && line_cnt != '1)
               line_cnt <= line_cnt + 1'b1;
            if (hit)
               shut_seen <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/exp_ms_timer.sv
module exp_ms_timer #(
   parameter int TW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          enable,
   input  logic          tick,
   input  logic [TW-1:0] target,
   output logic          reached
);
   logic [TW-1:0] cnt;

   assign reached = (cnt == target);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clear)
         cnt <= '0;
      else if (enable && tick && !reached)
         cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/exposure_frame_ctrl.sv
module exposure_frame_ctrl
   import exp_pkg::*;
#(
   parameter int SEL_W              = 5,
   parameter int LINES              = 1104,
   parameter int NO_SHUT_LINE       = 2040,
   parameter int SHUT_CODES         = 7,
   parameter int MS_STEP            = 4,
   parameter bit INTEG_FROM_SHUTTER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ms_tick,
   input  logic [SEL_W-1:0] int_sel,
   input  logic             line_adv,
   input  logic             readout_done,
   output logic             shut_pulse,
   output logic             vd_req,
   output logic             integrate
);
   localparam int LW      = $clog2(NO_SHUT_LINE + 1);
   localparam int MAX_TGT = ((1 << SEL_W) - 1 - SHUT_CODES) * MS_STEP;
   localparam int TW      = (MAX_TGT < 1) ? 1 : $clog2(MAX_TGT + 1);

   if (NO_SHUT_LINE < LINES) begin : g_chk_noshut
      $error("NO_SHUT_LINE must not fall inside the readout");
   end
   if (LINES / (SHUT_CODES + 1) < 1) begin : g_chk_step
      $error("LINES too small for SHUT_CODES");
   end
   if (SHUT_CODES >= (1 << SEL_W)) begin : g_chk_codes
      $error("SHUT_CODES exceeds select range");
   end
   if (MS_STEP < 1) begin : g_chk_ms
      $error("MS_STEP must be at least 1");
   end

   exp_state_t       state;
   logic [SEL_W-1:0] sel_q;
   logic [LW-1:0]    shut_line;
   logic [TW-1:0]    tick_target;
   logic             reached;
   logic             shut_seen;
   logic             frame_start;
   logic             integ_start;

   assign frame_start = (state == ST_PDXFER) && line_adv;
   assign integ_start = (state == ST_READOUT) && readout_done;

   exp_sel_decode #(
      .SEL_W(SEL_W), .LINES(LINES), .NO_SHUT_LINE(NO_SHUT_LINE),
      .SHUT_CODES(SHUT_CODES), .MS_STEP(MS_STEP), .LW(LW), .TW(TW)
   ) u_decode (
      .sel        (sel_q),
      .shut_line  (shut_line),
      .tick_target(tick_target)
   );

   exp_line_track #(.LW(LW)) u_lines (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (frame_start),
      .enable    (state == ST_READOUT),
      .line_adv  (line_adv),
      .shut_line (shut_line),
      .shut_pulse(shut_pulse),
      .shut_seen (shut_seen)
   );

   exp_ms_timer #(.TW(TW)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (integ_start),
      .enable (state == ST_INTEG),
      .tick   (ms_tick),
      .target (tick_target),
      .reached(reached)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_READOUT;
         sel_q  <= '0;
         vd_req <= 1'b0;
      end else begin
         vd_req <= 1'b0;
         case (state)
            ST_READOUT: if (readout_done) state <= ST_INTEG;
            ST_INTEG: if (reached) begin
               state  <= ST_PDXFER;
               vd_req <= 1'b1;
            end
            ST_PDXFER: if (line_adv) begin
               state <= ST_READOUT;
               sel_q <= int_sel;
            end
            default: state <= ST_READOUT;
         endcase
      end
   end

   if (INTEG_FROM_SHUTTER) begin : g_integ_shut
      assign integrate = (state == ST_INTEG) || ((state == ST_READOUT) && shut_seen);
   end else begin : g_integ_plain
      assign integrate = (state == ST_INTEG);
   end
endmodule

// File: rtl/exposure_frame_ctrl_chk.sv
module exposure_frame_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic shut_pulse,
   input logic vd_req,
   input logic integrate
);
   // R6: request lasts one cycle
   assert_vd_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vd_req |=> !vd_req);
   // R6: exposure indication is low during the request
   assert_vd_integ_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vd_req |-> !integrate);
   // R5: a request is preceded by an active integration cycle
   assert_vd_after_integ_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vd_req) |-> $past(integrate));
   // R7: a shutter pulse coincides with an active exposure
   assert_shut_integ_R7: assert property (@(posedge clk) disable iff (!rst_n)
      shut_pulse |-> integrate);
   // R3: shutter pulse lasts one cycle
   assert_shut_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      shut_pulse |=> !shut_pulse);
   // R9: shutter and request never share a cycle
   assert_shut_vd_apart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(shut_pulse && vd_req));
endmodule

bind exposure_frame_ctrl exposure_frame_ctrl_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .shut_pulse(shut_pulse),
   .vd_req    (vd_req),
   .integrate (integrate)
);

// File: tb/exposure_frame_ctrl_test.sv
module exposure_frame_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int SEL_W      = 5;
   localparam int LINES      = 16;
   localparam int SHUT_CODES = 7;
   localparam int MS_STEP    = 2;
   localparam int STEP       = LINES / (SHUT_CODES + 1);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ms_tick = 1'b0;
   logic [SEL_W-1:0] int_sel = '0;
   logic             line_adv = 1'b0;
   logic             readout_done = 1'b0;
   logic             shut_pulse, vd_req, integrate;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exposure_frame_ctrl #(
      .SEL_W(SEL_W), .LINES(LINES), .NO_SHUT_LINE(2040),
      .SHUT_CODES(SHUT_CODES), .MS_STEP(MS_STEP), .INTEG_FROM_SHUTTER(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .int_sel(int_sel),
      .line_adv(line_adv), .readout_done(readout_done),
      .shut_pulse(shut_pulse), .vd_req(vd_req), .integrate(integrate)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int exp_line(input int s);
      return (s >= 1 && s <= SHUT_CODES) ? LINES - s * STEP : -1;
   endfunction

   function automatic int exp_ticks(input int s);
      return (s > SHUT_CODES) ? (s - SHUT_CODES) * MS_STEP : 0;
   endfunction

   // one frame with latched code s; coincide ends readout on the shutter line
   task automatic run_frame(input int s, input bit coincide);
      int es = exp_line(s);
      int nt = exp_ticks(s);
      int nl = coincide ? es + 1 : LINES;
      for (int i = 0; i < nl; i++) begin
         @(negedge clk);
         line_adv = 1'b1;
         if (coincide && i == es) readout_done = 1'b1;
         if (i == 3) int_sel = SEL_W'(s ^ 21); // R2: mid-frame change ignored
         @(negedge clk);
         line_adv = 1'b0;
         readout_done = 1'b0;
         chk((es >= 0) ? "R3 shutter line" : "R4 no shutter", int'(shut_pulse), int'(i == es));
         if (i == es) chk(coincide ? "R9 shutter with readout end" : "R7 integrate after shutter",
                          int'(integrate), 1);
         if (i == 0) chk("R2 latched code", int'(shut_pulse), int'(es == 0));
      end
      if (!coincide) begin
         @(negedge clk);
         readout_done = 1'b1;
         @(negedge clk);
         readout_done = 1'b0;
      end
      chk("R7 integrate in integration", int'(integrate), 1);
      chk("R5 no early request", int'(vd_req), 0);
      for (int k = 0; k < nt; k++) begin
         @(negedge clk);
         ms_tick = 1'b1;
         @(negedge clk);
         ms_tick = 1'b0;
         chk("R5 no early request", int'(vd_req), 0);
      end
      @(negedge clk);
      chk("R5 request timing", int'(vd_req), 1);
      chk("R6 integrate low at request", int'(integrate), 0);
      @(negedge clk);
      chk("R6 single-cycle request", int'(vd_req), 0);
      // R8: waiting in photodiode transfer
      ms_tick = 1'b1;
      readout_done = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk("R8 ignored in transfer", int'(vd_req) + int'(integrate), 0);
      end
      ms_tick = 1'b0;
      readout_done = 1'b0;
   endtask

   task automatic restart(input int s);
      @(negedge clk);
      int_sel = SEL_W'(s);
      line_adv = 1'b1;
      @(negedge clk);
      line_adv = 1'b0;
      chk("R8 restart line not counted", int'(shut_pulse), 0);
      chk("R6 integrate low after request", int'(integrate), 0);
   endtask

   initial begin
      int_sel = 5'd9;
      repeat (3) @(negedge clk);
      chk("R1 reset shutter", int'(shut_pulse), 0);
      chk("R1 reset request", int'(vd_req), 0);
      chk("R1 reset integrate", int'(integrate), 0);
      rst_n = 1'b1;
      run_frame(0, 1'b0);   // R1: code 0 in force despite int_sel=9
      for (int s = 1; s < (1 << SEL_W); s++) begin
         restart(s);
         run_frame(s, 1'b0);
      end
      restart(1);
      run_frame(1, 1'b1);   // R9 collision
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule